// File: doc/BRIEF.md
# Downstream Port Status and Control Register

This block holds the status and control state of one downstream port of a USB host root hub. Software reaches it through a single 32-bit register. A bit position can mean one thing when read and a different command when written. On a read, the low bits report what the port hardware sees: connect, enable, suspend, over-current, reset in progress, power and a low-speed device. On a write, a 1 in the same positions is a command: clear or set enable, enter or leave suspend, start a reset, or switch power on or off. A 0 in any command position does nothing.

Five sticky change flags, in bits 20 down to 16, record events that software has not yet acknowledged. Software clears a flag by writing a 1 to its position. The OR of the five flags drives an interrupt request toward the hub. A port reset lasts a fixed number of clock cycles, set by a parameter. When the reset ends, the block enables the port and raises the reset-change flag.

The register interface is plain and unflowed. A write is taken in any cycle in which `wr_en` is high. Read data is always valid. There is no back-pressure.

Top module: `hub_port_status`

## Requirements
- R1: After reset, `rd_data` is 0 and the outputs `port_en`, `port_susp`, `port_rst`, `port_pwr` and `chg_irq` are 0.
- R2: Read layout:
  - bit 0 is the connect input and bit 3 is the over-current input, each as registered one cycle earlier.
  - bit 9 is the low-speed input, read only while connected.
  - bit 1 is enable, bit 2 is suspend, bit 4 is reset in progress and bit 8 is power.
  - bits 16..20 are the change flags for connect, enable, suspend, over-current and reset.
  - All other bits read 0.
- R3: Enable commands:
  - Writing bit 0 = 1 clears enable.
  - Writing bit 1 = 1 sets enable, but only while bit 0 reads 1.
  - When both bits are written as 1 together, the clear wins.
- R4: Suspend commands:
  - Writing bit 2 = 1 enters suspend, but only while the port is both connected and enabled.
  - Writing bit 3 = 1 leaves suspend. If the port was suspended, this also sets bit 18.
- R5: Port reset:
  - Writing bit 4 = 1 while connected raises `port_rst` for exactly RST_CYCLES cycles and clears suspend.
  - When the count completes, the port is enabled and bit 20 is set.
  - A reset cut short by a disconnect or a power-off sets neither.
- R6: Power commands:
  - Writing bit 8 = 1 turns power on. Writing bit 9 = 1 turns power off.
  - When both are written as 1 together, off wins.
  - Power-off also clears enable and suspend and ends any reset in progress.
- R7: Writing a 1 to any of bits 16..20 clears that change flag. If hardware sets the same flag in the same cycle, the set wins.
- R8: Connect and disconnect:
  - Any change on the connect input sets bit 16.
  - A disconnect also clears enable and suspend, ends any reset, and sets bit 17 if the port was enabled.
- R9: A rising over-current input sets bit 19 and clears enable. It also sets bit 17 if the port was enabled.
- R10: `chg_irq` is high exactly when any of bits 16..20 is set.
- R11: A write of all zeros changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value (commands and flag clears) |
| rd_data | output | 32 | Register read value |
| dev_present | input | 1 | Device connected on the port |
| dev_lowspeed | input | 1 | Attached device is low speed |
| dev_overcur | input | 1 | Port over-current indication |
| port_en | output | 1 | Port enabled |
| port_susp | output | 1 | Port suspended |
| port_rst | output | 1 | Port reset in progress |
| port_pwr | output | 1 | Port power switch on |
| chg_irq | output | 1 | Any change flag set |

## Verification
The bench builds the block with RST_CYCLES = 4. With this short value, the bench can sample both the last cycle in which the reset is held and the cycle in which it completes, within a few steps. This covers R5's exact length and its handshake with enable and bit 20. The same short window lets the bench abort a reset by power-off and by disconnect, then wait longer than a full reset to confirm that no completion follows. It also makes a disconnect that coincides with a flag-clear write easy to drive, which tests that a hardware set takes priority over the clear.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;
  localparam int REG_W      = 32;
  // read bits / write command bits (positions decoded by software)
  localparam int B_CONN_CLREN   = 0;
  localparam int B_EN_SETEN     = 1;
  localparam int B_SUSP_SETSUSP = 2;
  localparam int B_OC_CLRSUSP   = 3;
  localparam int B_RST_SETRST   = 4;
  localparam int B_PWR_PWRON    = 8;
  localparam int B_LS_PWROFF    = 9;
  // change flags
  localparam int NUM_CHG    = 5;
  localparam int CHG_LO     = 16;
  localparam int CHG_HI     = CHG_LO + NUM_CHG - 1;
  localparam int F_CONN     = 0;
  localparam int F_EN       = 1;
  localparam int F_SUSP     = 2;
  localparam int F_OC       = 3;
  localparam int F_RST      = 4;
endpackage

// File: rtl/hub_port_sense.sv
module hub_port_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_present,
  input  logic dev_lowspeed,
  input  logic dev_overcur,
  output logic conn_q,
  output logic ls_q,
  output logic oc_q,
  output logic conn_rise,
  output logic conn_fall,
  output logic oc_rise
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      ls_q   <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      conn_q <= dev_present;
      ls_q   <= dev_lowspeed;
      oc_q   <= dev_overcur;
    end
  end

  assign conn_rise = dev_present & ~conn_q;
  assign conn_fall = ~dev_present & conn_q;
  assign oc_rise   = dev_overcur & ~oc_q;
endmodule

// File: rtl/hub_port_rst_timer.sv
module hub_port_rst_timer #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy & (cnt == '0) & ~abort & ~start;
endmodule

// File: rtl/hub_port_chg_flags.sv
module hub_port_chg_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hub_port_status.sv
module hub_port_status
  import hub_port_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dev_present,
  input  logic             dev_lowspeed,
  input  logic             dev_overcur,
  output logic             port_en,
  output logic             port_susp,
  output logic             port_rst,
  output logic             port_pwr,
  output logic             chg_irq
);
  logic conn_q, ls_q, oc_q, conn_rise, conn_fall, oc_rise;
  logic [REG_W-1:0] cmd;
  logic en_q, susp_q, pwr_q;
  logic rst_busy, rst_done, rst_start, rst_abort;
  logic en_kill, susp_kill;
  logic [NUM_CHG-1:0] chg_set, chg_flags;

  hub_port_sense u_sense (
    .clk(clk), .rst_n(rst_n),
    .dev_present(dev_present), .dev_lowspeed(dev_lowspeed), .dev_overcur(dev_overcur),
    .conn_q(conn_q), .ls_q(ls_q), .oc_q(oc_q),
    .conn_rise(conn_rise), .conn_fall(conn_fall), .oc_rise(oc_rise)
  );

  assign cmd = wr_en ? wr_data : '0;

  assign rst_abort = conn_fall | cmd[B_LS_PWROFF];
  assign rst_start = cmd[B_RST_SETRST] & conn_q & ~rst_abort;

  hub_port_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(rst_start), .abort(rst_abort),
    .busy(rst_busy), .done(rst_done)
  );

  assign en_kill   = conn_fall | oc_rise | cmd[B_LS_PWROFF] | cmd[B_CONN_CLREN];
  assign susp_kill = en_kill | rst_start | cmd[B_OC_CLRSUSP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      if (en_kill)
        en_q <= 1'b0;
      else if (rst_done || (cmd[B_EN_SETEN] && conn_q))
        en_q <= 1'b1;

      if (susp_kill)
        susp_q <= 1'b0;
      else if (cmd[B_SUSP_SETSUSP] && conn_q && en_q)
        susp_q <= 1'b1;

      if (cmd[B_LS_PWROFF])
        pwr_q <= 1'b0;
      else if (cmd[B_PWR_PWRON])
        pwr_q <= 1'b1;
    end
  end

  always_comb begin
    chg_set         = '0;
    chg_set[F_CONN] = conn_rise | conn_fall;
    chg_set[F_EN]   = (conn_fall | oc_rise) & en_q;
    chg_set[F_SUSP] = cmd[B_OC_CLRSUSP] & susp_q;
    chg_set[F_OC]   = oc_rise;
    chg_set[F_RST]  = rst_done;
  end

  hub_port_chg_flags #(.N(NUM_CHG)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set(chg_set), .clr(cmd[CHG_HI:CHG_LO]),
    .flags(chg_flags)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[B_CONN_CLREN]   = conn_q;
    rd_data[B_EN_SETEN]     = en_q;
    rd_data[B_SUSP_SETSUSP] = susp_q;
    rd_data[B_OC_CLRSUSP]   = oc_q;
    rd_data[B_RST_SETRST]   = rst_busy;
    rd_data[B_PWR_PWRON]    = pwr_q;
    rd_data[B_LS_PWROFF]    = ls_q & conn_q;
    rd_data[CHG_HI:CHG_LO]  = chg_flags;
  end

  assign port_en   = en_q;
  assign port_susp = susp_q;
  assign port_rst  = rst_busy;
  assign port_pwr  = pwr_q;
  assign chg_irq   = |chg_flags;
endmodule

// File: rtl/hub_port_status_chk.sv
module hub_port_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic        port_en,
  input logic        port_susp,
  input logic        port_rst,
  input logic        chg_irq
);
  // R8
  disc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[0]) |-> (rd_data[16] && !port_en));

  // R3
  en_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> rd_data[0]);

  // R4
  susp_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_susp |-> (rd_data[0] && port_en));

  // R5
  rst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(port_rst) && port_en) |-> rd_data[20]);

  // R5
  rst_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |-> rd_data[0]);

  // R10
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_irq == (|rd_data[20:16]));
endmodule

bind hub_port_status hub_port_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data),
  .port_en(port_en), .port_susp(port_susp), .port_rst(port_rst),
  .chg_irq(chg_irq)
);

// File: tb/hub_port_status_test.sv
module hub_port_status_test;
  localparam int NRST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dev_present = 1'b0, dev_lowspeed = 1'b0, dev_overcur = 1'b0;
  logic        port_en, port_susp, port_rst, port_pwr, chg_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] rd;
    string       req;
  } exp_t;
  exp_t sb[$];
  event chk_ev;

  always #5 clk = ~clk;

  hub_port_status #(.RST_CYCLES(NRST)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_present(dev_present), .dev_lowspeed(dev_lowspeed), .dev_overcur(dev_overcur),
    .port_en(port_en), .port_susp(port_susp), .port_rst(port_rst),
    .port_pwr(port_pwr), .chg_irq(chg_irq)
  );

  task automatic drain();
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      logic [4:0] act_o = {port_en, port_susp, port_rst, port_pwr, chg_irq};
      logic [4:0] exp_o = {e.rd[1], e.rd[2], e.rd[4], e.rd[8], |e.rd[20:16]};
      n_tests++;
      if (rd_data !== e.rd || act_o !== exp_o) begin
        n_fail++;
        $display("FAIL %s: rd_data=%h outs=%b expected rd_data=%h outs=%b",
                 e.req, rd_data, act_o, e.rd, exp_o);
      end
    end
  endtask

  // monitor
  initial forever begin
    @(chk_ev);
    drain();
  end

  task automatic expect_rd(input logic [31:0] v, input string req);
    exp_t e;
    e.rd = v;
    e.req = req;
    sb.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_rd(32'h0, "R1");
    step(1);
    wr(32'h0);                  expect_rd(32'h0, "R11");
    wr(32'h2);                  expect_rd(32'h0, "R3 set-en without device");
    wr(32'h100);                expect_rd(32'h100, "R6 power on");
    dev_present = 1; dev_lowspeed = 1;
    step(1);                    expect_rd(32'h10301, "R2 R8 R10 connect");
    wr(32'h10000);              expect_rd(32'h301, "R7 clear connect flag");
    wr(32'h0);                  expect_rd(32'h301, "R11 zero write");
    wr(32'h2);                  expect_rd(32'h303, "R3 set enable");
    wr(32'h3);                  expect_rd(32'h301, "R3 clear wins");
    wr(32'h10);                 expect_rd(32'h311, "R5 reset start");
    step(NRST - 1);             expect_rd(32'h311, "R5 reset held");
    step(1);                    expect_rd(32'h100303, "R5 reset done");
    wr(32'h100000);             expect_rd(32'h303, "R7 clear reset flag");
    wr(32'h4);                  expect_rd(32'h307, "R4 suspend");
    wr(32'h8);                  expect_rd(32'h40303, "R4 resume");
    wr(32'h40000);              expect_rd(32'h303, "R7 clear suspend flag");
    dev_overcur = 1;
    step(1);                    expect_rd(32'hA0309, "R9 over-current");
    dev_overcur = 0;
    step(1);                    expect_rd(32'hA0301, "R9 over-current gone");
    wr(32'hA0000);              expect_rd(32'h301, "R7 clear two flags");
    wr(32'h2);                  expect_rd(32'h303, "R3 re-enable");
    dev_present = 0; dev_lowspeed = 0;
    wr(32'h30000);              expect_rd(32'h30100, "R7 R8 set beats clear on disconnect");
    wr(32'h200);                expect_rd(32'h30000, "R6 power off");
    wr(32'h1F0000);             expect_rd(32'h0, "R7 clear all");
    dev_present = 1;
    step(1);                    expect_rd(32'h10001, "R8 full-speed connect");
    wr(32'h10000);              expect_rd(32'h1, "R7");
    wr(32'h4);                  expect_rd(32'h1, "R4 suspend needs enable");
    wr(32'h100);                expect_rd(32'h101, "R6");
    wr(32'h10);                 expect_rd(32'h111, "R5 reset start");
    wr(32'h300);                expect_rd(32'h1, "R6 off wins, reset aborted");
    step(NRST + 1);             expect_rd(32'h1, "R5 no completion after abort");
    wr(32'h100);                expect_rd(32'h101, "R6");
    wr(32'h10);                 expect_rd(32'h111, "R5 reset start");
    dev_present = 0;
    step(1);                    expect_rd(32'h10100, "R8 disconnect aborts reset");
    step(NRST + 1);             expect_rd(32'h10100, "R5 no completion after disconnect");
    wr(32'h10);                 expect_rd(32'h10100, "R5 reset needs device");
    step(1);
    drain();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule